// File: doc/BRIEF.md
# UART Interrupt Combiner

This block gathers the four interrupt causes of one serial port (receive, error, transmit and modem) into a single level-sensitive interrupt request. Each cause arrives as a one-cycle set pulse and is latched in a four-bit source register. A four-bit mask register chooses which latched causes may reach the interrupt line. The pending value is the latched causes that the mask does not block. Software reads the source, pending and mask values through a small register port and clears causes by writing ones.

The transmit cause also has a level-driven set path. While FIFO mode is enabled and the transmit FIFO holds no more entries than a trigger threshold, the transmit bit is set again on every clock. The threshold is a 3-bit trigger field multiplied by a factor fixed by the channel-number parameter. The multiplier is chosen at elaboration, so every channel gets only the shift it needs.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Source bit positions are receive = bit 0, error = bit 1, transmit = bit 2 and modem = bit 3. A set pulse on a cause makes its bit read as 1 from the next clock.
- R2: A read of address 1 (pending) returns the source bits ANDed with the inverted mask, in the same cycle.
- R3: `irq` is registered. It is high one clock after any pending bit is set and low one clock after no pending bit is set.
- R4: Writing to address 1 clears every source bit (and so the pending bit) that has a 1 in `wr_data`. Bits written with 0 keep their value.
- R5: Writing to address 0 clears every source bit that has a 1 in `wr_data`. Bits written with 0 keep their value.
- R6: Writing to address 2 loads `wr_data` into the mask, and address 2 reads it back. A mask bit of 1 blocks that cause.
- R7: With `fifo_en` high and `tx_count` at or below the threshold, the transmit bit (bit 2) is set at the next clock. With `fifo_en` low, `tx_count` never sets it.
- R8: The threshold is `tx_trig` times 32 for channel 0, times 8 for channels 1 and 4, and times 2 for channels 2 and 3. Every other channel uses a threshold of 0.
- R9: When a set and a software clear reach the same bit in one cycle, the bit ends up set.
- R10: After reset, the source and mask registers read 0, pending reads 0 and `irq` is low.
- R11: With `rd_en` low, `rd_data` is 0. Address 3 always reads 0.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_rx | input | 1 | Receive cause set pulse |
| set_err | input | 1 | Error cause set pulse |
| set_tx | input | 1 | Transmit cause set pulse (byte completed) |
| set_modem | input | 1 | Modem cause set pulse |
| fifo_en | input | 1 | FIFO mode enable |
| tx_count | input | CNT_W | Current transmit FIFO occupancy |
| tx_trig | input | TRIG_W | Transmit trigger field |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 source, 1 pending, 2 mask, 3 unused |
| wr_data | input | 4 | Write data |
| rd_data | output | 4 | Read data, combinational |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong source or mask bit shows up on the pending read at once. It reaches `irq` exactly one clock later, so a model that tracks both registers cycle by cycle finds the first wrong cycle. The bench runs three instances with channels 0, 2 and 7 in parallel. A wrong threshold multiplier therefore shows as a transmit bit that appears, or fails to appear, one clock after a `tx_count` value near the boundary. Same-cycle set and clear collisions come from both directed and random stimulus. This shows a wrong priority on the next read.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int NCAUSE = 4;

    localparam int BIT_RX    = 0;
    localparam int BIT_ERR   = 1;
    localparam int BIT_TX    = 2;
    localparam int BIT_MODEM = 3;

    typedef enum logic [1:0] {
        SEL_SRC  = 2'd0,
        SEL_PEND = 2'd1,
        SEL_MASK = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef logic [NCAUSE-1:0] cause_t;
endpackage

// File: rtl/uirq_tx_level.sv
module uirq_tx_level #(
    parameter int CHANNEL = 0,
    parameter int CNT_W   = 8,
    parameter int TRIG_W  = 3
) (
    input  logic              fifo_en,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [TRIG_W-1:0] tx_trig,
    output logic              tx_low
);
    localparam int  THR_W = TRIG_W + 5;
    localparam int  CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;
    localparam bit  NO_THR = !(CHANNEL >= 0 && CHANNEL <= 4);
    localparam int  SHIFT = (CHANNEL == 0) ? 5 :
                            (CHANNEL == 1 || CHANNEL == 4) ? 3 :
                            (CHANNEL == 2 || CHANNEL == 3) ? 1 : 0;

    logic [THR_W-1:0] thr;

    generate
        if (NO_THR) begin : g_zero
            assign thr = '0;
        end else begin : g_scaled
            assign thr = THR_W'(tx_trig) << SHIFT;
        end
    endgenerate

    assign tx_low = fifo_en && (CMP_W'(tx_count) <= CMP_W'(thr));
endmodule

// File: rtl/uirq_src_bank.sv
module uirq_src_bank
    import uirq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  cause_t set_vec,
    input  cause_t clr_vec,
    output cause_t src_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
        end else begin
            src_q <= (src_q & ~clr_vec) | set_vec;
        end
    end

    generate
        for (genvar i = 0; i < NCAUSE; i++) begin : g_chk
            assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
                set_vec[i] |=> src_q[i]);
            // set beats clear (R9)
            assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (set_vec[i] && clr_vec[i]) |=> src_q[i]);
            assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_vec[i] && !set_vec[i]) |=> !src_q[i]);
            assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_vec[i] && !set_vec[i]) |=> $stable(src_q[i]));
        end
    endgenerate
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uirq_pkg::*;
#(
    parameter int CHANNEL = 0,
    parameter int CNT_W   = 8,
    parameter int TRIG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_rx,
    input  logic              set_err,
    input  logic              set_tx,
    input  logic              set_modem,
    input  logic              fifo_en,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [TRIG_W-1:0] tx_trig,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [3:0]        wr_data,
    output logic [3:0]        rd_data,
    output logic              irq
);
    reg_sel_e sel;
    logic     tx_low;
    cause_t   set_vec;
    cause_t   clr_vec;
    cause_t   src_q;
    cause_t   mask_q;
    cause_t   pend;

    assign sel = reg_sel_e'(addr);

    uirq_tx_level #(
        .CHANNEL (CHANNEL),
        .CNT_W   (CNT_W),
        .TRIG_W  (TRIG_W)
    ) u_level (
        .fifo_en  (fifo_en),
        .tx_count (tx_count),
        .tx_trig  (tx_trig),
        .tx_low   (tx_low)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[BIT_RX]    = set_rx;
        set_vec[BIT_ERR]   = set_err;
        set_vec[BIT_TX]    = set_tx | tx_low;
        set_vec[BIT_MODEM] = set_modem;
    end

    always_comb begin
        clr_vec = '0;
        if (wr_en && (sel == SEL_SRC || sel == SEL_PEND)) begin
            clr_vec = wr_data;
        end
    end

    uirq_src_bank u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .src_q   (src_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en && sel == SEL_MASK) begin
            mask_q <= wr_data;
        end
    end

    assign pend = src_q & ~mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= |pend;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_SRC:  rd_data = src_q;
                SEL_PEND: rd_data = pend;
                SEL_MASK: rd_data = mask_q;
                SEL_NONE: rd_data = '0;
            endcase
        end
    end

    assert_irq_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_q & ~mask_q)) |=> irq);
    assert_irq_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(src_q & ~mask_q)) |=> !irq);
    assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd2) |=> mask_q == $past(wr_data));
    assert_tx_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_low |=> src_q[BIT_TX]);
    assert_pend_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1 && wr_data[BIT_MODEM] && !set_modem) |=> !src_q[BIT_MODEM]);
endmodule

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 8;
    localparam int TRIG_W = 3;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst_n, set_rx, set_err, set_tx, set_modem, fifo_en, wr_en, rd_en;
    logic [CNT_W-1:0]  tx_count;
    logic [TRIG_W-1:0] tx_trig;
    logic [1:0] addr;
    logic [3:0] wr_data;
    logic [3:0] rd_v [3];
    logic       irq_v [3];

    uart_irq_ctrl #(.CHANNEL(0), .CNT_W(CNT_W), .TRIG_W(TRIG_W)) dut (
        .clk(clk), .rst_n(rst_n), .set_rx(set_rx), .set_err(set_err), .set_tx(set_tx),
        .set_modem(set_modem), .fifo_en(fifo_en), .tx_count(tx_count), .tx_trig(tx_trig),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_v[0]), .irq(irq_v[0]));
    uart_irq_ctrl #(.CHANNEL(2), .CNT_W(CNT_W), .TRIG_W(TRIG_W)) dut_c2 (
        .clk(clk), .rst_n(rst_n), .set_rx(set_rx), .set_err(set_err), .set_tx(set_tx),
        .set_modem(set_modem), .fifo_en(fifo_en), .tx_count(tx_count), .tx_trig(tx_trig),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_v[1]), .irq(irq_v[1]));
    uart_irq_ctrl #(.CHANNEL(7), .CNT_W(CNT_W), .TRIG_W(TRIG_W)) dut_c7 (
        .clk(clk), .rst_n(rst_n), .set_rx(set_rx), .set_err(set_err), .set_tx(set_tx),
        .set_modem(set_modem), .fifo_en(fifo_en), .tx_count(tx_count), .tx_trig(tx_trig),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_v[2]), .irq(irq_v[2]));

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int chan [3] = '{0, 2, 7};
    logic [3:0] src_m [3];
    logic [3:0] mask_m;
    logic       irq_m [3];

    function automatic int thr_of(int ch, int trig);
        if (ch == 0) return trig * 32;
        if (ch == 1 || ch == 4) return trig * 8;
        if (ch == 2 || ch == 3) return trig * 2;
        return 0;
    endfunction

    function automatic logic [3:0] read_model(int k, logic [1:0] a);
        case (a)
            2'd0: return src_m[k];
            2'd1: return src_m[k] & ~mask_m;
            2'd2: return mask_m;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic [3:0] next_src(int k);
        logic [3:0] setv, clrv;
        setv = {set_modem,
                set_tx | (fifo_en && (int'(tx_count) <= thr_of(chan[k], int'(tx_trig)))),
                set_err, set_rx};
        clrv = (wr_en && (addr == 2'd0 || addr == 2'd1)) ? wr_data : 4'd0;
        return (src_m[k] & ~clrv) | setv;
    endfunction

    task automatic chk(string tag, int k, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s inst %0d actual %h expected %h at %0t", tag, k, act, exp, $time);
        end
    endtask

    task automatic idle();
        set_rx = 0; set_err = 0; set_tx = 0; set_modem = 0;
        fifo_en = 0; tx_count = '0; tx_trig = '0;
        wr_en = 0; rd_en = 0; addr = 2'd0; wr_data = 4'd0;
    endtask

    task automatic step(string tag);
        logic [3:0] nsrc [3];
        logic [3:0] nmask;
        logic       nirq [3];
        string rt, it;
        #1;
        if (rd_en) begin
            rt = (tag != "") ? tag : (addr == 2'd0) ? "R1" : (addr == 2'd1) ? "R2" :
                 (addr == 2'd2) ? "R6" : "R11";
            for (int k = 0; k < 3; k++) chk(rt, k, rd_v[k], read_model(k, addr));
        end else begin
            for (int k = 0; k < 3; k++) chk("R11", k, rd_v[k], 4'd0);
        end
        for (int k = 0; k < 3; k++) begin
            nsrc[k] = next_src(k);
            nirq[k] = |(src_m[k] & ~mask_m);
        end
        nmask = (wr_en && addr == 2'd2) ? wr_data : mask_m;
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            src_m[k] = nsrc[k];
            irq_m[k] = nirq[k];
        end
        mask_m = nmask;
        it = (tag != "") ? tag : "R3";
        for (int k = 0; k < 3; k++) chk(it, k, {3'd0, irq_v[k]}, {3'd0, irq_m[k]});
        idle();
    endtask

    task automatic rd(logic [1:0] a, string tag);
        rd_en = 1; addr = a; step(tag);
    endtask

    task automatic wr(logic [1:0] a, logic [3:0] d, string tag);
        wr_en = 1; addr = a; wr_data = d; step(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        idle();
        rst_n = 0;
        for (int k = 0; k < 3; k++) begin src_m[k] = 4'd0; irq_m[k] = 1'b0; end
        mask_m = 4'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R10: reset values
        for (int a = 0; a < 4; a++) rd(2'(a), "R10");

        // R1/R2/R3: modem cause, unmasked
        set_modem = 1; step("R1");
        rd(2'd0, "R1");
        rd(2'd1, "R2");
        // R6: mask blocks it, irq falls
        wr(2'd2, 4'b1000, "R6");
        rd(2'd2, "R6");
        rd(2'd1, "R2");
        step("R3");
        wr(2'd2, 4'b0000, "R6");
        // R4: pending write clears source
        set_err = 1; step("R1");
        wr(2'd1, 4'b1010, "R4");
        rd(2'd0, "R4");
        // R9: set wins over clear
        set_rx = 1; wr(2'd0, 4'b0001, "R9");
        rd(2'd0, "R9");
        // R5: source clear
        wr(2'd0, 4'b1111, "R5");
        rd(2'd0, "R5");
        // R8: thresholds, trigger 1 and count 2 (ch0 32, ch2 2, ch7 0)
        fifo_en = 1; tx_trig = 3'd1; tx_count = 8'd2; step("R8");
        rd(2'd0, "R8");
        wr(2'd0, 4'b1111, "R5");
        fifo_en = 1; tx_trig = 3'd1; tx_count = 8'd3; step("R8");
        rd(2'd0, "R8");
        wr(2'd0, 4'b1111, "R5");
        fifo_en = 1; tx_trig = 3'd7; tx_count = 8'd224; step("R8");
        rd(2'd0, "R8");
        wr(2'd0, 4'b1111, "R5");
        fifo_en = 1; tx_trig = 3'd0; tx_count = 8'd0; step("R8");
        rd(2'd0, "R8");
        wr(2'd0, 4'b1111, "R5");
        // R7: FIFO mode off ignores the count
        fifo_en = 0; tx_trig = 3'd7; tx_count = 8'd0; step("R7");
        rd(2'd0, "R7");
        set_tx = 1; step("R7");
        rd(2'd0, "R1");
        // R11: address 3 and idle read
        rd(2'd3, "R11");
        step("R11");

        // random phase
        for (int n = 0; n < 3000; n++) begin
            set_rx    = ($urandom % 8) == 0;
            set_err   = ($urandom % 8) == 0;
            set_tx    = ($urandom % 8) == 0;
            set_modem = ($urandom % 8) == 0;
            fifo_en   = ($urandom % 4) == 0;
            tx_count  = ($urandom % 2) ? 8'($urandom % 8) : 8'($urandom % 256);
            tx_trig   = 3'($urandom % 8);
            wr_en     = ($urandom % 4) == 0;
            rd_en     = ($urandom % 2) == 0;
            addr      = 2'($urandom % 4);
            wr_data   = 4'($urandom % 16);
            step("");
        end
        finish_run();
    end
endmodule